// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of an external parallel flash and decides when an embedded program or erase operation has finished. After a start pulse it issues status reads through a read request/acknowledge handshake. It compares the toggle bit of successive status bytes and watches the timeout bit. It ends each run with a pass or a fail verdict. The pin-level bus timing sits behind the handshake and is not part of this block.

The toggle bit is checked first. When it has stopped, the operation is complete. When it is still moving and the timeout bit is low, the poller reads again and compares with the previous byte. When the timeout bit is high, the poller takes two fresh reads before it fails the operation. This catches the case where the toggle bit stops in the same moment the timeout bit rises. A fail verdict is reported only after the poller has written the reset command, which returns the device to array reads.

A host that needs the bus can raise `yield`. The poller then parks at its next decision point. When `yield` falls it starts again with a fresh pair of reads. A poll limit stops the machine from waiting forever.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `result` is 00 (idle), `done` is low and neither `rd_req` nor `wr_req` is asserted.
- R2: A `start` pulse while idle sets `result` to 01 (busy). No verdict is given before two status reads have completed.
- R3: `rd_req` stays high until a cycle with `rd_ack` high, and `rd_data` is taken in that cycle. The toggle bit is bit `TOG_BIT` (default 6) and the timeout bit is bit `TMO_BIT` (default 5). No other data bit affects the outcome.
- R4: If the toggle bit of a read equals that of the read before it, the run ends with `result` 10 (pass) and no write is issued.
- R5: If the toggle bit changed and the timeout bit of the newer read is 0, exactly one more read is taken and compared with that newer read.
- R6: If the toggle bit changed and the timeout bit of the newer read is 1, two more reads are taken and compared with each other. If they are equal, the result is pass.
- R7: If those two recheck reads differ, `wr_req` is raised with `wr_data` = F0h until `wr_ack`. The run then ends with `result` 11 (fail).
- R8: If `yield` is high at a decision that would continue polling (R5), no read is requested while `yield` stays high. After `yield` falls, polling restarts with two fresh reads that do not use any earlier value.
- R9: If a toggling, timeout-low decision happens when the total number of reads since start has reached `MAX_READS`, the run fails through the reset write of R7.
- R10: `done` is high for exactly one cycle per run, in the cycle after the final acknowledge. `result` keeps its verdict until the next start.
- R11: A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a polling run (one-cycle pulse) |
| yield | input | 1 | Request to park polling and free the bus |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Status byte returned by the read |
| wr_req | output | 1 | Reset-command write request |
| wr_data | output | DW | Data for the write (F0h) |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 idle, 01 busy, 10 pass, 11 fail |

## Verification
Some properties are checked on every cycle by the embedded assertions. These are the handshake holds, the single-cycle `done` pulse, the rule that a pass is preceded by a read acknowledge and a fail by a write acknowledge, and the rule that `done` never appears with a busy result. Only the bench's scenarios can show the rest. That covers the verdicts and the read counts that follow from a given sequence of toggle and timeout bits, including the recheck race and the poll limit. It also covers the fresh restart after parking and the ignored start during a run. The bench checks these over a sweep of toggle-stop points, timeout onsets and acknowledge delays.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int DW        = 8,
  parameter int TOG_BIT   = 6,
  parameter int TMO_BIT   = 5,
  parameter int MAX_READS = 256,
  parameter logic [7:0] RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          yield,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          done,
  output logic [1:0]    result
);

  localparam int CW = $clog2(MAX_READS + 3);
  localparam logic [1:0] RES_IDLE = 2'b00;
  localparam logic [1:0] RES_BUSY = 2'b01;
  localparam logic [1:0] RES_PASS = 2'b10;
  localparam logic [1:0] RES_FAIL = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_A, S_RD_B, S_RX_A, S_RX_B, S_PARK, S_WR
  } st_t;

  st_t           st;
  logic          prev_bit;
  logic [CW-1:0] nreads;

  wire toggled  = rd_data[TOG_BIT] ^ prev_bit;
  wire tmo_high = rd_data[TMO_BIT];
  wire at_limit = (32'(nreads) + 32'd1) >= 32'(MAX_READS);

  assign rd_req  = (st == S_RD_A) || (st == S_RD_B) || (st == S_RX_A) || (st == S_RX_B);
  assign wr_req  = (st == S_WR);
  assign wr_data = DW'(RST_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      prev_bit <= 1'b0;
      nreads   <= '0;
      done     <= 1'b0;
      result   <= RES_IDLE;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st     <= S_RD_A;
          nreads <= '0;
          result <= RES_BUSY;
        end
        S_RD_A, S_RX_A: if (rd_ack) begin
          prev_bit <= rd_data[TOG_BIT];
          nreads   <= nreads + 1'b1;
          st       <= (st == S_RD_A) ? S_RD_B : S_RX_B;
        end
        S_RD_B: if (rd_ack) begin
          nreads <= nreads + 1'b1;
          if (!toggled) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            result <= RES_PASS;
          end else if (tmo_high) begin
            st <= S_RX_A;
          end else if (at_limit) begin
            st <= S_WR;
          end else begin
            prev_bit <= rd_data[TOG_BIT];
            if (yield) st <= S_PARK;
          end
        end
        S_RX_B: if (rd_ack) begin
          nreads <= nreads + 1'b1;
          if (toggled) begin
            st <= S_WR;
          end else begin
            st     <= S_IDLE;
            done   <= 1'b1;
            result <= RES_PASS;
          end
        end
        S_PARK: if (!yield) st <= S_RD_A;
        S_WR: if (wr_ack) begin
          st     <= S_IDLE;
          done   <= 1'b1;
          result <= RES_FAIL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_fail_after_wack: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_FAIL |-> $past(wr_ack));
  a_r4_pass_after_rack: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RES_PASS |-> $past(rd_ack));
  a_r2_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    result == RES_BUSY |-> !done);

endmodule

// File: tb/sim_toggle_poll_ctrl.sv
module sim_toggle_poll_ctrl;
  localparam int MX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, yield = 1'b0;
  logic rd_req, rd_ack = 1'b0, wr_req, wr_ack = 1'b0, done;
  logic [7:0] rd_data = 8'h00, wr_data;
  logic [1:0] result;

  always #2 clk = ~clk;

  toggle_poll_ctrl #(.MAX_READS(MX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .yield(yield),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .result(result));

  int checks = 0, fails = 0;
  int m_n = 0, m_k = 100, m_frz = 1000, m_lat = 0, idx = 0, wait_c = 0;
  bit m_fv = 1'b0;
  int nwr = 0, ndone = 0, wwait = 0;
  logic [7:0] last_wd = 8'h00;
  logic [1:0] last_res = 2'b00;

  function automatic bit tog_val(int i);
    if (i >= m_frz) return m_fv;
    if (i < m_n) return i[0];
    return (m_n > 0) ? 1'((m_n - 1) & 1) : 1'b0;
  endfunction

  // flash model: acknowledges after m_lat idle cycles, noise on the other bits
  initial forever begin
    @(negedge clk);
    if (done) begin ndone++; last_res = result; end
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (wait_c >= m_lat) begin
        rd_data = 8'(idx * 37 + 11);
        rd_data[6] = tog_val(idx);
        rd_data[5] = (idx >= m_k);
        rd_ack = 1'b1; idx++; wait_c = 0;
      end else wait_c++;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      if (wwait >= m_lat) begin
        wr_ack = 1'b1; nwr++; last_wd = wr_data; wwait = 0;
      end else wwait++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_run(int n, int k, output int reads, output bit fail);
    fail = 0; reads = 2;
    for (int j = 1; j < 64; j++) begin
      reads = j + 1;
      if (!(j < n)) begin fail = 0; return; end        // R4
      if (j >= k) begin reads = j + 3; fail = (j + 2 < n); return; end  // R6 / R7
      if (j + 1 >= MX) begin fail = 1; return; end     // R9
    end                                                 // else R5: one more read
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (ndone == 0 && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) chk(1'b0, {req, " watchdog"}, t, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(int n, int k, int lat);
    m_n = n; m_k = k; m_lat = lat; m_frz = 1000;
    idx = 0; nwr = 0; ndone = 0; wait_c = 0; wwait = 0;
  endtask

  initial begin
    int er; bit ef;
    repeat (3) @(negedge clk);
    chk(result == 2'b00, "R1 result", result, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
    chk(wr_req == 1'b0, "R1 wr_req", wr_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep over toggle-stop point n, timeout onset k, ack latency
    for (int n = 0; n < 10; n++) begin
      for (int k = 0; k < 11; k++) begin
        setup(n, k, (n + k) % 3);
        expect_run(n, k, er, ef);
        pulse_start();
        chk(result == 2'b01, "R2 busy", result, 1);
        wait_done("R5");
        chk(idx == er, "R5 R6 R9 read count", idx, er);
        chk(last_res == (ef ? 2'b11 : 2'b10), "R4 R6 R7 verdict", last_res, ef ? 3 : 2);
        chk(nwr == (ef ? 1 : 0), "R7 reset write", nwr, ef ? 1 : 0);
        chk(ndone == 1, "R10 done count", ndone, 1);
        if (ef) chk(last_wd == 8'hF0, "R7 write data", last_wd, 8'hF0);
        chk(result == last_res, "R10 result held", result, last_res);
      end
    end

    // R8: park at first decision, device settles while parked
    setup(20, 100, 1);
    m_frz = 2; m_fv = 1'b1;
    yield = 1'b1;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(idx == 2, "R8 reads before park", idx, 2);
    chk(rd_req == 1'b0, "R8 no read while parked", rd_req, 0);
    yield = 1'b0;
    wait_done("R8");
    chk(idx == 4, "R8 fresh double read", idx, 4);
    chk(last_res == 2'b10, "R8 verdict", last_res, 2);

    // R11: start during a run is ignored
    setup(6, 100, 2);
    expect_run(6, 100, er, ef);
    pulse_start();
    while (idx < 3) @(negedge clk);
    pulse_start();
    wait_done("R11");
    chk(idx == er, "R11 read count", idx, er);
    chk(ndone == 1, "R11 single done", ndone, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL global watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule